// File: doc/BRIEF.md
# Streaming Complex Multiplier with Stream Join

The block multiplies two complex sample streams, one sample from each, and emits their product as a third stream. The first input (A) carries data samples. The second input (B) carries the samples of a unit-amplitude sinusoid, such as a phase-to-amplitude converter produces. Each of the three ports uses a valid/ready handshake. The block only takes a beat from A in a cycle where it also takes a beat from B, so the two inputs are joined into one product stream.

The two inputs have different formats. An A component is a 21-bit signed value with 15 fractional bits, sign-extended into a 24-bit lane. A B component is a 16-bit signed value with 14 fractional bits. Every product and sum is formed at its full 38-bit precision. Each result component then loses its 6 least significant bits by a plain arithmetic shift, which leaves a 32-bit value with 23 fractional bits. A two-stage pipeline holds the partial products and then the combined result. A single stall signal, taken from the output register, advances both stages together.

Top module: `cmul_stream`

## Requirements
- R1: An active-high synchronous reset clears both pipeline stages. `y_valid` is 0 while `rst` is high and in the first cycle after it falls, and no beat that entered before the reset ever leaves the block.
- R2: A beat from A is accepted (`a_valid && a_ready`) in exactly the cycles in which a beat from B is accepted (`b_valid && b_ready`).
- R3: `a_ready` does not depend on `a_valid`, and `b_ready` does not depend on `b_valid`. `a_ready` is 0 whenever `b_valid` is 0, and `b_ready` is 0 whenever `a_valid` is 0. When the output register is empty, each ready equals the other port's valid.
- R4: In each input word, bits [23:0] hold the real part and bits [47:24] hold the imaginary part for A. For B, bits [15:0] hold the real part and bits [31:16] hold the imaginary part. The operands are the signed values of A lane bits [20:0] and of the full B lanes. The output computes real = Ar·Br − Ai·Bi and imaginary = Ar·Bi + Ai·Br, at full precision.
- R5: Each output component equals its full-precision result shifted right arithmetically by 6 bits and taken to 32 bits. The shift rounds toward negative infinity, so a negative result that has nonzero low bits moves further from zero.
- R6: In `y_data`, bits [31:0] hold the real result and bits [63:32] hold the imaginary result.
- R7: `y_last` equals the `a_last` of the A beat the product came from. `b_last` has no effect on any output.
- R8: When `y_ready` is held high, a pair accepted at one clock edge appears on the output two edges later.
- R9: When both inputs stay valid and `y_ready` stays high, the block accepts a pair and delivers a product on every clock.
- R10: While `y_valid` is 1 and `y_ready` is 0, the output word and `y_last` stay stable, both input readys are 0, and no product is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| a_data | input | 48 | Data sample: imaginary lane [47:24], real lane [23:0] |
| a_last | input | 1 | End-of-packet flag of the data sample |
| a_valid | input | 1 | A beat is offered |
| a_ready | output | 1 | A beat is taken at this edge if valid |
| b_data | input | 32 | Sinusoid sample: imaginary [31:16], real [15:0] |
| b_last | input | 1 | End-of-packet flag of the sinusoid sample (unused) |
| b_valid | input | 1 | B beat is offered |
| b_ready | output | 1 | B beat is taken at this edge if valid |
| y_data | output | 64 | Product: imaginary [63:32], real [31:0] |
| y_last | output | 1 | End-of-packet flag carried from A |
| y_valid | output | 1 | Product beat is offered |
| y_ready | input | 1 | Downstream takes the product beat |

## Verification
The assertions assume that neither source withdraws or alters a beat it has offered before that beat is taken. They also assume that each A lane arrives correctly sign-extended, so that bits 23:21 copy bit 20. The bench keeps to both rules. Its drivers hold each word steady until the handshake completes, and they build every A lane by truncating a 21-bit signed integer. On top of that, the bench gates the two inputs and the output ready independently at random rates, so that both streams lead, lag and stall in every combination.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

  localparam int CMUL_A_LANE_W = 24;
  localparam int CMUL_A_SIG_W  = 21;
  localparam int CMUL_B_W      = 16;
  localparam int CMUL_OUT_W    = 32;
  localparam int CMUL_N_PP     = 4;

  // Partial-product slots: real*real, imag*imag, real*imag, imag*real (A first)
  localparam int PP_RR = 0;
  localparam int PP_II = 1;
  localparam int PP_RI = 2;
  localparam int PP_IR = 3;

  function automatic bit pp_takes_a_imag(input int slot);
    return (slot == PP_II) || (slot == PP_IR);
  endfunction

  function automatic bit pp_takes_b_imag(input int slot);
    return (slot == PP_II) || (slot == PP_RI);
  endfunction

endpackage

// File: rtl/cmul_join.sv
module cmul_join (
  input  logic a_valid,
  input  logic b_valid,
  input  logic advance,
  output logic a_ready,
  output logic b_ready,
  output logic fire
);

  // each ready looks only at the opposite stream and the pipeline stall
  assign a_ready = advance & b_valid;
  assign b_ready = advance & a_valid;
  assign fire    = advance & a_valid & b_valid;

endmodule

// File: rtl/cmul_pp.sv
module cmul_pp
  import cmul_pkg::*;
#(
  parameter int A_SIG_W = CMUL_A_SIG_W,
  parameter int B_W     = CMUL_B_W
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            advance,
  input  logic                            fire,
  input  logic                            a_last,
  input  logic signed [A_SIG_W-1:0]       a_re,
  input  logic signed [A_SIG_W-1:0]       a_im,
  input  logic signed [B_W-1:0]           b_re,
  input  logic signed [B_W-1:0]           b_im,
  output logic                            s1_valid,
  output logic                            s1_last,
  output logic signed [A_SIG_W+B_W-1:0]   pp [CMUL_N_PP]
);

  localparam int PP_W = A_SIG_W + B_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
    end else if (advance) begin
      s1_valid <= fire;
    end
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      s1_last <= a_last;
    end
  end

  for (genvar k = 0; k < CMUL_N_PP; k++) begin : g_pp
    logic signed [A_SIG_W-1:0] op_a;
    logic signed [B_W-1:0]     op_b;
    logic signed [PP_W-1:0]    prod_q;

    if (pp_takes_a_imag(k)) begin : g_a_im
      assign op_a = a_im;
    end else begin : g_a_re
      assign op_a = a_re;
    end

    if (pp_takes_b_imag(k)) begin : g_b_im
      assign op_b = b_im;
    end else begin : g_b_re
      assign op_b = b_re;
    end

    always_ff @(posedge clk) begin
      if (fire) begin
        prod_q <= PP_W'(op_a) * PP_W'(op_b);
      end
    end

    assign pp[k] = prod_q;
  end

endmodule

// File: rtl/cmul_sum.sv
module cmul_sum
  import cmul_pkg::*;
#(
  parameter int PP_W  = CMUL_A_SIG_W + CMUL_B_W,
  parameter int OUT_W = CMUL_OUT_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   advance,
  input  logic                   s1_valid,
  input  logic                   s1_last,
  input  logic signed [PP_W-1:0] pp [CMUL_N_PP],
  output logic                   y_valid,
  output logic                   y_last,
  output logic [OUT_W-1:0]       y_re,
  output logic [OUT_W-1:0]       y_im
);

  localparam int FULL_W = PP_W + 1;

  function automatic logic signed [FULL_W-1:0] widen(input logic signed [PP_W-1:0] v);
    return FULL_W'(v);
  endfunction

  // arithmetic drop of the low bits: keep the top OUT_W bits of the full word
  function automatic logic [OUT_W-1:0] floor_drop(input logic signed [FULL_W-1:0] v);
    return v[FULL_W-1 -: OUT_W];
  endfunction

  logic signed [FULL_W-1:0] re_full;
  logic signed [FULL_W-1:0] im_full;

  assign re_full = widen(pp[PP_RR]) - widen(pp[PP_II]);
  assign im_full = widen(pp[PP_RI]) + widen(pp[PP_IR]);

  always_ff @(posedge clk) begin
    if (rst) begin
      y_valid <= 1'b0;
    end else if (advance) begin
      y_valid <= s1_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (advance && s1_valid) begin
      y_re   <= floor_drop(re_full);
      y_im   <= floor_drop(im_full);
      y_last <= s1_last;
    end
  end

endmodule

// File: rtl/cmul_stream.sv
module cmul_stream
  import cmul_pkg::*;
#(
  parameter int A_LANE_W = CMUL_A_LANE_W,
  parameter int A_SIG_W  = CMUL_A_SIG_W,
  parameter int B_W      = CMUL_B_W,
  parameter int OUT_W    = CMUL_OUT_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2*A_LANE_W-1:0] a_data,
  input  logic                  a_last,
  input  logic                  a_valid,
  output logic                  a_ready,
  input  logic [2*B_W-1:0]      b_data,
  input  logic                  b_last,
  input  logic                  b_valid,
  output logic                  b_ready,
  output logic [2*OUT_W-1:0]    y_data,
  output logic                  y_last,
  output logic                  y_valid,
  input  logic                  y_ready
);

  localparam int PP_W = A_SIG_W + B_W;

  // named internal events, observed by the bound checker
  logic advance;
  logic fire;

  logic signed [A_SIG_W-1:0] a_re, a_im;
  logic signed [B_W-1:0]     b_re, b_im;
  logic                      s1_valid, s1_last;
  logic signed [PP_W-1:0]    pp [CMUL_N_PP];
  logic [OUT_W-1:0]          y_re, y_im;

  assign a_re = a_data[A_SIG_W-1:0];
  assign a_im = a_data[A_LANE_W +: A_SIG_W];
  assign b_re = b_data[B_W-1:0];
  assign b_im = b_data[B_W +: B_W];

  // sign-extension copies in the A lanes and the B end flag carry no information
  logic unused_bits;
  assign unused_bits = ^{b_last, a_data[A_LANE_W-1:A_SIG_W], a_data[2*A_LANE_W-1:A_LANE_W+A_SIG_W]};

  assign advance = ~y_valid | y_ready;

  cmul_join i_join (
    .a_valid (a_valid),
    .b_valid (b_valid),
    .advance (advance),
    .a_ready (a_ready),
    .b_ready (b_ready),
    .fire    (fire)
  );

  cmul_pp #(
    .A_SIG_W (A_SIG_W),
    .B_W     (B_W)
  ) i_pp (
    .clk      (clk),
    .rst      (rst),
    .advance  (advance),
    .fire     (fire),
    .a_last   (a_last),
    .a_re     (a_re),
    .a_im     (a_im),
    .b_re     (b_re),
    .b_im     (b_im),
    .s1_valid (s1_valid),
    .s1_last  (s1_last),
    .pp       (pp)
  );

  cmul_sum #(
    .PP_W  (PP_W),
    .OUT_W (OUT_W)
  ) i_sum (
    .clk      (clk),
    .rst      (rst),
    .advance  (advance),
    .s1_valid (s1_valid),
    .s1_last  (s1_last),
    .pp       (pp),
    .y_valid  (y_valid),
    .y_last   (y_last),
    .y_re     (y_re),
    .y_im     (y_im)
  );

  assign y_data = {y_im, y_re};

endmodule

// File: rtl/cmul_stream_chk.sv
module cmul_stream_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              a_valid,
  input logic              a_ready,
  input logic              b_valid,
  input logic              b_ready,
  input logic [DATA_W-1:0] y_data,
  input logic              y_last,
  input logic              y_valid,
  input logic              y_ready,
  input logic              advance,
  input logic              fire
);

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> !y_valid); // R1

  AST_JOIN_A_WITH_B: assert property (@(posedge clk) disable iff (rst) (a_valid && a_ready) |-> (b_valid && b_ready)); // R2

  AST_JOIN_B_WITH_A: assert property (@(posedge clk) disable iff (rst) (b_valid && b_ready) |-> (a_valid && a_ready)); // R2

  AST_FIRE_IS_PAIR: assert property (@(posedge clk) disable iff (rst) fire |-> (a_ready && b_ready)); // R2

  AST_A_RDY_NEEDS_B: assert property (@(posedge clk) disable iff (rst) !b_valid |-> !a_ready); // R3

  AST_B_RDY_NEEDS_A: assert property (@(posedge clk) disable iff (rst) !a_valid |-> !b_ready); // R3

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst) (y_valid && !y_ready) |-> (!a_ready && !b_ready && !advance)); // R10

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst)
    (y_valid && !y_ready) |=> (y_valid && $stable(y_data) && $stable(y_last))); // R10

endmodule

bind cmul_stream cmul_stream_chk #(.DATA_W(2*OUT_W)) i_chk (
  .clk     (clk),
  .rst     (rst),
  .a_valid (a_valid),
  .a_ready (a_ready),
  .b_valid (b_valid),
  .b_ready (b_ready),
  .y_data  (y_data),
  .y_last  (y_last),
  .y_valid (y_valid),
  .y_ready (y_ready),
  .advance (advance),
  .fire    (fire)
);

// File: tb/test_cmul_stream.sv
module test_cmul_stream;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = CLK_PERIOD / 2;
  localparam int A_LANE_W   = 24;
  localparam int B_W        = 16;
  localparam int OUT_W      = 32;
  localparam int DROP       = 6;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic [2*A_LANE_W-1:0] a_data = '0;
  logic                  a_last = 1'b0;
  logic                  a_valid = 1'b0;
  logic                  a_ready;
  logic [2*B_W-1:0]      b_data = '0;
  logic                  b_last = 1'b0;
  logic                  b_valid = 1'b0;
  logic                  b_ready;
  logic [2*OUT_W-1:0]    y_data;
  logic                  y_last;
  logic                  y_valid;
  logic                  y_ready = 1'b0;

  always #(HALF) clk = ~clk;

  cmul_stream i_cmul_stream (
    .clk     (clk),
    .rst     (rst),
    .a_data  (a_data),
    .a_last  (a_last),
    .a_valid (a_valid),
    .a_ready (a_ready),
    .b_data  (b_data),
    .b_last  (b_last),
    .b_valid (b_valid),
    .b_ready (b_ready),
    .y_data  (y_data),
    .y_last  (y_last),
    .y_valid (y_valid),
    .y_ready (y_ready)
  );

  int total = 0;
  int bad = 0;
  int sample_no = 0;
  bit finished = 0;

  int sa_i[$], sa_q[$], sb_i[$], sb_q[$];
  bit sa_l[$], sb_l[$];
  int pend_a[$], pend_b[$];
  logic [64:0] qexp[$];
  int a_idx, b_idx, n_out;
  bit a_took, b_took, hold_prev;
  logic [64:0] prev_word;
  int first_fire_s, first_out_s, last_out_s;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [64:0] act, input logic [64:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // full-precision complex product, then floor-shift and 32-bit take; {last, imag, real}
  function automatic logic [64:0] model(input int ar, input int ai, input int br, input int bi, input bit l);
    longint re, im;
    re = longint'(ar) * longint'(br) - longint'(ai) * longint'(bi);
    im = longint'(ar) * longint'(bi) + longint'(ai) * longint'(br);
    return {l, 32'(im >>> DROP), 32'(re >>> DROP)};
  endfunction

  function automatic bit pick(input int pct);
    return ($urandom % 100) < pct;
  endfunction

  task automatic new_phase();
    sa_i.delete(); sa_q.delete(); sa_l.delete();
    sb_i.delete(); sb_q.delete(); sb_l.delete();
    pend_a.delete(); pend_b.delete(); qexp.delete();
    a_idx = 0; b_idx = 0; n_out = 0;
    a_took = 0; b_took = 0; hold_prev = 0;
    a_valid = 0; b_valid = 0;
    first_fire_s = -1; first_out_s = -1; last_out_s = -1;
  endtask

  task automatic add_pair(input int ar, input int ai, input int br, input int bi);
    sa_i.push_back(ar); sa_q.push_back(ai); sa_l.push_back(bit'($urandom % 2));
    sb_i.push_back(br); sb_q.push_back(bi); sb_l.push_back(bit'($urandom % 2));
  endtask

  task automatic sample_cycle();
    sample_no++;
    if (hold_prev)
      check(y_valid === 1'b1 && {y_last, y_data} === prev_word, "R10", "output changed under stall",
            {y_last, y_data}, prev_word);
    hold_prev = y_valid && !y_ready;
    prev_word = {y_last, y_data};
    if ((a_valid && a_ready) || (b_valid && b_ready))
      check((a_valid && a_ready) && (b_valid && b_ready), "R2", "one-sided acceptance",
            65'({a_valid, a_ready, b_valid, b_ready}), 65'hF);
    if (a_valid && a_ready) begin
      pend_a.push_back(a_idx); a_took = 1;
      if (first_fire_s < 0) first_fire_s = sample_no;
    end
    if (b_valid && b_ready) begin
      pend_b.push_back(b_idx); b_took = 1;
    end
    while (pend_a.size() > 0 && pend_b.size() > 0) begin
      int ia = pend_a.pop_front();
      int ib = pend_b.pop_front();
      qexp.push_back(model(sa_i[ia], sa_q[ia], sb_i[ib], sb_q[ib], sa_l[ia]));
    end
    if (y_valid && y_ready) begin
      n_out++;
      if (first_out_s < 0) first_out_s = sample_no;
      last_out_s = sample_no;
      if (qexp.size() == 0) begin
        check(0, "R1", "product with no matching input pair", {y_last, y_data}, '0);
      end else begin
        logic [64:0] e = qexp.pop_front();
        // R4 arithmetic, R5 floor drop, R6 packing, R7 last from A
        check({y_last, y_data} === e, "R4/R5/R6/R7", "product word", {y_last, y_data}, e);
      end
    end
  endtask

  task automatic run_stream(input int a_pct, input int b_pct, input int r_pct, input int max_cycles);
    int guard = 0;
    while (n_out < sa_i.size() && guard < max_cycles) begin
      @(negedge clk);
      if (a_took) begin a_valid = 0; a_took = 0; a_idx++; end
      if (b_took) begin b_valid = 0; b_took = 0; b_idx++; end
      if (!a_valid && a_idx < sa_i.size() && pick(a_pct)) begin
        a_data  = {A_LANE_W'(sa_q[a_idx]), A_LANE_W'(sa_i[a_idx])};
        a_last  = sa_l[a_idx];
        a_valid = 1;
      end
      if (!b_valid && b_idx < sb_i.size() && pick(b_pct)) begin
        b_data  = {B_W'(sb_q[b_idx]), B_W'(sb_i[b_idx])};
        b_last  = sb_l[b_idx];
        b_valid = 1;
      end
      y_ready = pick(r_pct);
      #(HALF - 1);
      sample_cycle();
      guard++;
    end
  endtask

  task automatic phase_done(input string what);
    check(n_out == sa_i.size() && qexp.size() == 0, "R10", what, 65'(n_out), 65'(sa_i.size()));
  endtask

  initial begin
    int av[6];
    int bv[6];
    av = '{1048575, -1048576, 0, 1, -1, 12345};
    bv = '{32767, -32768, 0, 1, -1, -12345};

    // R1: output empty during and right after reset
    repeat (3) @(negedge clk);
    #(HALF - 1);
    check(y_valid === 1'b0, "R1", "valid during reset", 65'(y_valid), 65'd0);
    @(negedge clk);
    rst = 0;
    #(HALF - 1);
    check(y_valid === 1'b0, "R1", "valid after reset", 65'(y_valid), 65'd0);

    // R3: each ready follows only the opposite valid
    @(negedge clk);
    a_valid = 1; b_valid = 0;
    #(HALF - 1);
    check(a_ready === 1'b0, "R3", "a_ready without b_valid", 65'(a_ready), 65'd0);
    check(b_ready === 1'b1, "R3", "b_ready with a_valid", 65'(b_ready), 65'd1);
    @(negedge clk);
    a_valid = 0; b_valid = 1;
    #(HALF - 1);
    check(b_ready === 1'b0, "R3", "b_ready without a_valid", 65'(b_ready), 65'd0);
    check(a_ready === 1'b1, "R3", "a_ready with b_valid", 65'(a_ready), 65'd1);
    @(negedge clk);
    b_valid = 0;

    // R8: latency of a single pair
    new_phase();
    add_pair(-3, 700, 16384, -16384);
    run_stream(100, 100, 100, 50);
    phase_done("R8 single pair delivered");
    check(first_out_s - first_fire_s == 2, "R8", "latency in cycles",
          65'(first_out_s - first_fire_s), 65'd2);

    // R9: back-to-back throughput
    new_phase();
    for (int k = 0; k < 64; k++) add_pair(int'($urandom) >>> 11, int'($urandom) >>> 11,
                                          int'($urandom) >>> 16, int'($urandom) >>> 16);
    run_stream(100, 100, 100, 400);
    phase_done("R9 burst delivered");
    check(last_out_s - first_out_s == 63, "R9", "burst span", 65'(last_out_s - first_out_s), 65'd63);

    // R4/R5/R6: every combination of corner values, with gaps on all three ports
    new_phase();
    for (int p = 0; p < 6; p++)
      for (int q = 0; q < 6; q++)
        for (int r = 0; r < 6; r++)
          for (int s = 0; s < 6; s++)
            add_pair(av[p], av[q], bv[r], bv[s]);
    run_stream(70, 60, 70, 20000);
    phase_done("R4 corner sweep delivered");

    // R10/R7: full-range values under heavy backpressure, random end flags on both inputs
    new_phase();
    for (int k = 0; k < 1500; k++) add_pair(int'($urandom) >>> 11, int'($urandom) >>> 11,
                                            int'($urandom) >>> 16, int'($urandom) >>> 16);
    run_stream(50, 80, 40, 30000);
    phase_done("R10 backpressure stream delivered");

    // R1: reset while the pipeline is full drops everything in flight
    new_phase();
    for (int k = 0; k < 8; k++) add_pair(k + 5, -k, 1000, 2000);
    run_stream(100, 100, 0, 6);
    check(y_valid === 1'b1, "R10", "pipeline filled under stall", 65'(y_valid), 65'd1);
    @(negedge clk);
    rst = 1; a_valid = 0; b_valid = 0; y_ready = 1;
    @(negedge clk);
    rst = 0;
    #(HALF - 1);
    check(y_valid === 1'b0, "R1", "valid after mid-stream reset", 65'(y_valid), 65'd0);
    new_phase();
    for (int k = 0; k < 4; k++) add_pair(-k - 1, 3 * k, -2000, 777);
    run_stream(100, 100, 100, 100);
    phase_done("R1 fresh stream after reset");

    @(negedge clk);
    a_valid = 0; b_valid = 0;
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule